// File: doc/BRIEF.md
# Edge-Capture Interrupt Unit

This unit watches the lowest 24 general-purpose I/O lines, eight lines to a port across ports 0 to 2, and records edges on them. Each line has its own direction select (rising or falling) and its own enable. A qualifying edge on an enabled line sets that line's bit in an event register, and the bit stays set until software clears it. The event bits are folded into a 3-bit per-port pending summary and a level interrupt request. Lines 24 and above are handled elsewhere.

Software reaches the three 24-bit registers one byte at a time through a paged window driven by the neighbouring port bank. The window has a 2-bit page select and a byte index:

- page 1 is direction,
- page 2 is enable,
- page 3 is events.

Page 0 belongs to the port bank and reads as zero here.

Each pin passes through a two-flop synchronizer and one history flop. A small state machine gates edge detection after reset until the history flop holds a real sample:

- SY_LOAD is entered on reset and always moves to SY_SETTLE.
- SY_SETTLE always moves to SY_HIST.
- SY_HIST always moves to SY_LIVE.
- SY_LIVE holds, and edges are reported only in this state.

Top module: `edc_capture`

## Requirements
- R1: While reset is asserted, the direction, enable and event registers all read zero, `pend_status` is 3'b000 and `irq` is 0.
- R2: With direction bit 1 (rising) and enable bit 1, a 0-to-1 change on a pin sets that line's event bit on the third rising clock edge after the change, and not before.
- R3: With direction bit 0 (falling) and enable bit 1, a 1-to-0 change sets the event bit. A 0-to-1 change on the same line sets nothing.
- R4: A line whose enable bit is 0 never sets its event bit, whatever the pin does. Later enabling the line does not surface edges that happened while it was disabled.
- R5: Changing a direction bit while the pin is steady creates no event. Detection compares successive pin samples only.
- R6: A write to page 3, byte p, keeps only the event bits of port p whose data bit is 1. Writing 0x00 clears that port, and the other ports are untouched.
- R7: If a new event and a clearing write hit the same bit in the same clock, the bit ends up set.
- R8: `pend_status[p]` is 1 exactly when the event byte of port p is nonzero, and `irq` is 1 while any pending bit is 1.
- R9: Reads of page 1, 2 or 3 at byte 0..2 return that register byte, with bit 0 of byte p being line 8p. Page 0, and byte index 3 on any page, read 0x00. Writes there change nothing.
- R10: Pin levels present when reset is released produce no event, even when direction and enable are set in the first clocks after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 24 | Raw pin levels, line n on bit n |
| reg_wr | input | 1 | Write strobe for the paged window |
| reg_page | input | 2 | Page select (1 direction, 2 enable, 3 events) |
| reg_idx | input | 2 | Byte index inside the page (port number) |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte for the current page and index |
| pend_status | output | 3 | Per-port pending summary |
| irq | output | 1 | Level interrupt request |

## Verification
The clocked properties assume that the write strobe, page, index and data are stable around each rising edge and are held for exactly one clock. The bench drives all of them on the falling edge through one write task. The properties also assume that pins may change asynchronously but are sampled only through the synchronizer. The bench changes pins on falling edges and counts three rising edges to the latch point. That count is what lets the same-clock collision between an edge and a clearing write be placed exactly.

// File: rtl/edc_pkg.sv
package edc_pkg;
    // Page codes decoded from the shared paged window
    typedef enum logic [1:0] {
        PG_PORT     = 2'd0,
        PG_POLARITY = 2'd1,
        PG_ENABLE   = 2'd2,
        PG_EVENT    = 2'd3
    } page_e;

    // Warm-up sequence of the pin sampler
    typedef enum logic [1:0] {
        SY_LOAD,
        SY_SETTLE,
        SY_HIST,
        SY_LIVE
    } sync_state_e;
endpackage

// File: rtl/edc_detect.sv
module edc_detect
    import edc_pkg::*;
#(
    parameter int LINES = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pin_i,
    input  logic [LINES-1:0] pol_i,
    output logic [LINES-1:0] evt_o
);
    sync_state_e      st_q, st_nx;
    logic [LINES-1:0] meta_q, stab_q, hist_q;
    logic             live;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SY_LOAD;
        else        st_q <= st_nx;
    end

    // Next state: three clocks until the history flop holds a synchronized sample
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            SY_LOAD:   st_nx = SY_SETTLE;
            SY_SETTLE: st_nx = SY_HIST;
            SY_HIST:   st_nx = SY_LIVE;
            SY_LIVE:   st_nx = SY_LIVE;
            default:   st_nx = SY_LOAD;
        endcase
    end

    // Synchronizer and history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pin_i;
            stab_q <= meta_q;
            hist_q <= stab_q;
        end
    end

    // Outputs
    always_comb live = (st_q == SY_LIVE);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign evt_o[i] = live & (pol_i[i] ? ( stab_q[i] & ~hist_q[i])
                                           : (~stab_q[i] &  hist_q[i]));
    end

    // A steady synchronized pin yields no event, whatever the direction bits (R5)
    assert_flat_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stab_q == hist_q) |-> (evt_o == '0));

    // No event leaves the sampler before the warm-up ends (R10)
    assert_warmup_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_nx != SY_LIVE) |-> (evt_o == '0));
endmodule

// File: rtl/edc_regs.sv
module edc_regs
    import edc_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int PORT_W    = 8,
    parameter int IDX_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_i,
    input  page_e                       page_i,
    input  logic [IDX_W-1:0]            idx_i,
    input  logic [PORT_W-1:0]           wdata_i,
    input  logic [NUM_PORTS*PORT_W-1:0] evt_i,
    output logic [NUM_PORTS*PORT_W-1:0] pol_o,
    output logic [NUM_PORTS*PORT_W-1:0] id_o,
    output logic [PORT_W-1:0]           rdata_o
);
    localparam int LINES = NUM_PORTS * PORT_W;

    logic [LINES-1:0]     pol_q, en_q, id_q, id_nx, latch;
    logic [NUM_PORTS-1:0] hit;

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++)
            hit[p] = wr_i && (idx_i == IDX_W'(p));
    end

    // Event register next value: masked clear first, then new events win
    always_comb begin
        latch = evt_i & en_q;
        id_nx = id_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (hit[p] && page_i == PG_EVENT)
                id_nx[p*PORT_W +: PORT_W] = id_q[p*PORT_W +: PORT_W] & wdata_i;
        end
        id_nx = id_nx | latch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q <= '0;
            en_q  <= '0;
            id_q  <= '0;
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (hit[p] && page_i == PG_POLARITY) pol_q[p*PORT_W +: PORT_W] <= wdata_i;
                if (hit[p] && page_i == PG_ENABLE)   en_q[p*PORT_W +: PORT_W]  <= wdata_i;
            end
            id_q <= id_nx;
        end
    end

    // Read mux: unknown index or page 0 returns zero
    always_comb begin
        rdata_o = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (idx_i == IDX_W'(p)) begin
                case (page_i)
                    PG_POLARITY: rdata_o = pol_q[p*PORT_W +: PORT_W];
                    PG_ENABLE:   rdata_o = en_q[p*PORT_W +: PORT_W];
                    PG_EVENT:    rdata_o = id_q[p*PORT_W +: PORT_W];
                    default:     rdata_o = '0;
                endcase
            end
        end
    end

    assign pol_o = pol_q;
    assign id_o  = id_q;

    // Reset state (R1)
    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (pol_q == '0 && en_q == '0 && id_q == '0)
                else $error("registers not cleared in reset");
        end
    end

    // An enabled event is latched, even against a clearing write (R2, R7)
    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & en_q)) |=> ((id_q & $past(evt_i & en_q)) == $past(evt_i & en_q)));

    // Newly set event bits were enabled the clock before (R4)
    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((id_q & ~$past(id_q) & ~$past(en_q)) == '0));

    // Writing zero with no simultaneous event empties the port (R6)
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_clr_chk
        assert_zero_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[p] && page_i == PG_EVENT && wdata_i == '0
             && (evt_i[p*PORT_W +: PORT_W] & en_q[p*PORT_W +: PORT_W]) == '0)
            |=> (id_q[p*PORT_W +: PORT_W] == '0));
    end
endmodule

// File: rtl/edc_capture.sv
module edc_capture
    import edc_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int PORT_W    = 8,
    parameter int IDX_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_lvl,
    input  logic                        reg_wr,
    input  logic [1:0]                  reg_page,
    input  logic [IDX_W-1:0]            reg_idx,
    input  logic [PORT_W-1:0]           reg_wdata,
    output logic [PORT_W-1:0]           reg_rdata,
    output logic [NUM_PORTS-1:0]        pend_status,
    output logic                        irq
);
    localparam int LINES = NUM_PORTS * PORT_W;

    logic [LINES-1:0] pol, evt, id;

    edc_detect #(.LINES(LINES)) u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_lvl),
        .pol_i (pol),
        .evt_o (evt)
    );

    edc_regs #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .page_i  (page_e'(reg_page)),
        .idx_i   (reg_idx),
        .wdata_i (reg_wdata),
        .evt_i   (evt),
        .pol_o   (pol),
        .id_o    (id),
        .rdata_o (reg_rdata)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pend
        assign pend_status[p] = |id[p*PORT_W +: PORT_W];
    end

    assign irq = |pend_status;

    // The request follows the pending summary (R8)
    assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(irq) |-> (pend_status == '0)));
endmodule

// File: tb/edc_capture_test.sv
module edc_capture_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] pins;
    logic        wr;
    logic [1:0]  page;
    logic [1:0]  idx;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic [2:0]  pend;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    edc_capture uut (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pins), .reg_wr(wr), .reg_page(page),
        .reg_idx(idx), .reg_wdata(wdata), .reg_rdata(rdata),
        .pend_status(pend), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] pg, input logic [1:0] ix, input logic [7:0] d);
        wr = 1'b1; page = pg; idx = ix; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] pg, input logic [1:0] ix,
                          input logic [7:0] exp);
        page = pg; idx = ix;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_and_warmup;
        rst_n = 1'b0; pins = 24'hFFFFFF; wr = 1'b0; page = 2'd0; idx = 2'd0; wdata = 8'h00;
        wait_cyc(3);
        rd_chk("R1 pol0", 2'd1, 2'd0, 8'h00);
        rd_chk("R1 en1",  2'd2, 2'd1, 8'h00);
        rd_chk("R1 id2",  2'd3, 2'd2, 8'h00);
        chk("R1 pend", pend, 3'b000);
        chk("R1 irq", irq, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        wr_reg(2'd1, 2'd0, 8'hFF);
        wr_reg(2'd2, 2'd0, 8'hFF);
        wait_cyc(6);
        rd_chk("R10 no startup event", 2'd3, 2'd0, 8'h00);
        chk("R10 pend", pend, 3'b000);
        pins = 24'h000000;
        wait_cyc(5);
    endtask

    task automatic t_rise;
        wr_reg(2'd1, 2'd1, 8'hFF);
        wr_reg(2'd2, 2'd1, 8'hFF);
        pins[9] = 1'b1;
        wait_cyc(2);
        rd_chk("R2 not before third edge", 2'd3, 2'd1, 8'h00);
        wait_cyc(1);
        rd_chk("R2 rise latched", 2'd3, 2'd1, 8'h02);
        chk("R8 pend port1", pend, 3'b010);
        chk("R8 irq", irq, 1'b1);
    endtask

    task automatic t_fall;
        wr_reg(2'd2, 2'd2, 8'hFF);
        pins[20] = 1'b1;
        wait_cyc(4);
        rd_chk("R3 rise ignored", 2'd3, 2'd2, 8'h00);
        pins[20] = 1'b0;
        wait_cyc(4);
        rd_chk("R3 fall latched", 2'd3, 2'd2, 8'h10);
        chk("R8 pend two ports", pend, 3'b110);
    endtask

    task automatic t_polflip;
        wr_reg(2'd3, 2'd1, 8'h00);
        rd_chk("R6 cleared id1", 2'd3, 2'd1, 8'h00);
        wr_reg(2'd1, 2'd1, 8'h00);
        wait_cyc(4);
        rd_chk("R5 flip to falling", 2'd3, 2'd1, 8'h00);
        wr_reg(2'd1, 2'd1, 8'hFF);
        wait_cyc(4);
        rd_chk("R5 flip to rising", 2'd3, 2'd1, 8'h00);
        pins[9] = 1'b0;
        wait_cyc(4);
        pins[9] = 1'b1;
        wait_cyc(4);
        rd_chk("R2 second rise", 2'd3, 2'd1, 8'h02);
    endtask

    task automatic t_clear;
        wr_reg(2'd3, 2'd2, 8'hFF);
        rd_chk("R6 mask ones keep", 2'd3, 2'd2, 8'h10);
        wr_reg(2'd3, 2'd1, 8'h00);
        rd_chk("R6 port1 cleared", 2'd3, 2'd1, 8'h00);
        rd_chk("R6 port2 untouched", 2'd3, 2'd2, 8'h10);
        chk("R8 pend after clear", pend, 3'b100);
        chk("R8 irq still high", irq, 1'b1);
        wr_reg(2'd3, 2'd2, 8'h00);
        chk("R8 pend empty", pend, 3'b000);
        chk("R8 irq low", irq, 1'b0);
    endtask

    task automatic t_collide;
        pins[3] = 1'b1;
        wait_cyc(2);
        wr_reg(2'd3, 2'd0, 8'h00);
        rd_chk("R7 event wins over clear", 2'd3, 2'd0, 8'h08);
        wr_reg(2'd3, 2'd0, 8'h00);
        rd_chk("R6 later clear", 2'd3, 2'd0, 8'h00);
    endtask

    task automatic t_disabled;
        wr_reg(2'd2, 2'd0, 8'h00);
        pins[7:0] = 8'hF7;
        wait_cyc(4);
        rd_chk("R4 disabled rises", 2'd3, 2'd0, 8'h00);
        pins[7:0] = 8'h00;
        wait_cyc(4);
        rd_chk("R4 disabled falls", 2'd3, 2'd0, 8'h00);
        wr_reg(2'd2, 2'd0, 8'hFF);
        wait_cyc(4);
        rd_chk("R4 no stale edge", 2'd3, 2'd0, 8'h00);
        chk("R4 pend", pend, 3'b000);
    endtask

    task automatic t_access;
        rd_chk("R9 page0 reads zero", 2'd0, 2'd1, 8'h00);
        rd_chk("R9 idx3 reads zero", 2'd1, 2'd3, 8'h00);
        wr_reg(2'd1, 2'd3, 8'h5A);
        rd_chk("R9 pol0 kept", 2'd1, 2'd0, 8'hFF);
        rd_chk("R9 pol1 kept", 2'd1, 2'd1, 8'hFF);
        rd_chk("R9 pol2 kept", 2'd1, 2'd2, 8'h00);
        wr_reg(2'd0, 2'd1, 8'h00);
        rd_chk("R9 page0 write ignored pol", 2'd1, 2'd1, 8'hFF);
        rd_chk("R9 page0 write ignored en", 2'd2, 2'd1, 8'hFF);
        rd_chk("R9 en idx3 zero", 2'd2, 2'd3, 8'h00);
    endtask

    initial begin
        t_reset_and_warmup();
        t_rise();
        t_fall();
        t_polflip();
        t_clear();
        t_collide();
        t_disabled();
        t_access();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule